// File: doc/BRIEF.md
# Dual-Mode Per-Processor Counter-Timer

This block holds one timer per processor plus a shared mode register. Each timer runs in one of two modes, picked by that processor's bit in the mode register. In counter mode the timer counts up toward a programmable limit. When it gets there it wraps to zero, sets a sticky reached flag and raises its interrupt line. In user mode the same registers hold a 64-bit up-counter. Software writes its high and low words, starts and stops it, and it never interrupts.

The count advances in units of bit 9 of the 64-bit value, one unit every `TICK_DIV` clock cycles. `TICK_DIV` is 50 by default, which gives 500 ns at 100 MHz. The nine lowest bits always read as zero.

Software reaches the registers through a simple word port. `win_i` picks a window: 0 is the system window and k is processor k-1. `off_i` gives the byte offset inside the window. Reads come back combinationally on `rdata_o`. Any side effect of a read takes place at the clock edge where `rd_i` is high.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the mode register is 0, every timer is running in counter mode with limit 0 (status at offset 0x0C reads 1, offset 0x00 reads 0), and every interrupt is low.
- R2: At offset 0x10 of window 0, a write stores one mode bit per processor from data bits [N_CPU-1:0]; a read returns those bits with all higher bits zero. A 1 selects user mode, and each bit affects only its own timer.
- R3: In counter mode, a write at offset 0x00 sets the limit to data bits [30:9], clears the count and lowers the interrupt. On the tick that brings the count to the limit, the count wraps to 0, the reached flag is set and the interrupt rises. Offset 0x04 reads {reached, count[30:9], 9'b0}. A limit of 0 runs freely to 0x7FFFFE00.
- R4: In counter mode, a read at offset 0x00 returns {1'b0, limit[30:9], 9'b0}, clears the reached flag and lowers the interrupt.
- R5: In counter mode, a write at offset 0x08 sets the limit without clearing the count.
- R6: In counter mode, writes at offsets 0x04 and 0x0C have no effect: the timer keeps running and status reads 1.
- R7: When a mode bit goes 0 to 1, that timer lowers its interrupt, stops (status reads 0) and clears its count; the reached flag is kept.
- R8: In user mode, a write at offset 0x0C starts the counter when data bit 0 is 1 and stops it when bit 0 is 0. Status reads {31'b0, running}, and a stopped counter holds its value.
- R9: In user mode, offset 0x00 reads {reached, count[62:32]} and offset 0x04 reads {count[31:9], 9'b0}. A write at 0x00 loads count[62:32] from data bits [30:0], and a write at 0x04 loads count[31:9] from data bits [31:9]. Each write leaves the other half unchanged.
- R10: In user mode the limit is 0x7FFFFFFFFFFFFE00. Reaching it wraps the count to 0 and sets the reached flag, and the interrupt stays low.
- R11: When a mode bit goes 1 to 0, that timer runs again from count 0 with its previously programmed counter-mode limit.
- R12: While a timer runs, its count advances by exactly one unit of bit 9 every TICK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (applies read side effects) |
| win_i | input | $clog2(N_CPU+1) | Window select: 0 system, k processor k-1 |
| off_i | input | 5 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from win_i/off_i |
| irq_o | output | N_CPU | Per-processor interrupt, level |

## Verification
On every cycle the assertions check the following:
- A timer in user mode never drives its interrupt.
- Entering user mode always leaves the timer stopped with its interrupt low.
- Counter mode is never stopped.
- Every interrupt edge coincides with a set reached flag in counter mode.
- The mode register takes the written bits.

Some behaviour only the bench scenarios can show. These are the exact tick count over a measured window, the split 64-bit loads and readback, the wrap at the 64-bit limit, the difference between the clearing and the non-clearing limit writes, and that the limit survives a round trip through user mode.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int PER_W = 54;  // count bits above bit 9 of the 64-bit value
  localparam int CTR_W = 22;  // count bits used in counter mode
  localparam int LO_W  = 23;  // period bits held in the low word

  localparam logic [4:0] OFF_HI    = 5'h00;
  localparam logic [4:0] OFF_LO    = 5'h04;
  localparam logic [4:0] OFF_NORST = 5'h08;
  localparam logic [4:0] OFF_RUN   = 5'h0C;
  localparam logic [4:0] OFF_MODE  = 5'h10;

  typedef struct packed {
    logic        wr_hi;
    logic        wr_lo;
    logic        wr_norst;
    logic        wr_run;
    logic        rd_hi;
    logic [31:0] wdata;
  } dmt_cmd_t;
endpackage

// File: rtl/dmt_tick_gen.sv
module dmt_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dmt_mode_reg.sv
module dmt_mode_reg #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mode_o,
  output logic [N-1:0] to_user_o,
  output logic [N-1:0] to_ctr_o
);
  logic [N-1:0] mode_q;

  assign mode_o    = mode_q;
  assign to_user_o = {N{wr_i}} & wdata_i & ~mode_q;
  assign to_ctr_o  = {N{wr_i}} & ~wdata_i & mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (wr_i) mode_q <= wdata_i;
  end
endmodule

// File: rtl/dmt_cpu_timer.sv
module dmt_cpu_timer
  import dmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        user_i,
  input  logic        enter_user_i,
  input  logic        enter_ctr_i,
  input  dmt_cmd_t    cmd_i,
  output logic [31:0] rd_hi_o,
  output logic [31:0] rd_lo_o,
  output logic        run_o,
  output logic        reached_o,
  output logic        irq_o
);
  logic [PER_W-1:0] cnt_q, cnt_inc, lim_eff;
  logic [CTR_W-1:0] lim_q;
  logic             run_q, reached_q, irq_q, hit;

  always_comb begin
    if (user_i)          lim_eff = '1;
    else if (lim_q == '0) lim_eff = PER_W'({CTR_W{1'b1}});
    else                 lim_eff = PER_W'(lim_q);
  end

  assign cnt_inc = cnt_q + PER_W'(1);
  assign hit     = (cnt_inc >= lim_eff);  // also catches a limit lowered below the count

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      run_q     <= 1'b1;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else if (enter_user_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (enter_ctr_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else begin
      if (tick_i && run_q) begin
        if (hit) begin
          cnt_q     <= '0;
          reached_q <= 1'b1;
          if (!user_i) irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
      if (user_i) begin
        if (cmd_i.wr_hi)  cnt_q[PER_W-1:LO_W] <= cmd_i.wdata[30:0];
        if (cmd_i.wr_lo)  cnt_q[LO_W-1:0]     <= cmd_i.wdata[31:9];
        if (cmd_i.wr_run) run_q               <= cmd_i.wdata[0];
      end else begin
        if (cmd_i.wr_hi) begin
          lim_q <= cmd_i.wdata[30:9];
          cnt_q <= '0;
          irq_q <= 1'b0;
        end
        if (cmd_i.wr_norst) lim_q <= cmd_i.wdata[30:9];
        if (cmd_i.rd_hi) begin
          reached_q <= 1'b0;
          irq_q     <= 1'b0;
        end
      end
    end
  end

  assign rd_hi_o   = user_i ? {reached_q, cnt_q[PER_W-1:LO_W]} : {1'b0, lim_q, 9'b0};
  assign rd_lo_o   = user_i ? {cnt_q[LO_W-1:0], 9'b0} : {reached_q, cnt_q[CTR_W-1:0], 9'b0};
  assign run_o     = run_q;
  assign reached_o = reached_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dmt_pkg::*;
#(
  parameter int N_CPU    = 2,
  parameter int TICK_DIV = 50,
  localparam int WW      = $clog2(N_CPU + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [WW-1:0]    win_i,
  input  logic [4:0]       off_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic [N_CPU-1:0] irq_o
);
  logic             tick;
  logic             mode_wr;
  logic [N_CPU-1:0] mode_q, to_user, to_ctr, run_w, reach_w;
  logic [31:0]      hi_w [N_CPU];
  logic [31:0]      lo_w [N_CPU];

  dmt_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign mode_wr = wr_i && (win_i == '0) && (off_i == OFF_MODE);

  dmt_mode_reg #(.N(N_CPU)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (mode_wr),
    .wdata_i   (wdata_i[N_CPU-1:0]),
    .mode_o    (mode_q),
    .to_user_o (to_user),
    .to_ctr_o  (to_ctr)
  );

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    logic     sel;
    dmt_cmd_t cmd;

    assign sel          = (win_i == WW'(i + 1));
    assign cmd.wr_hi    = wr_i && sel && (off_i == OFF_HI);
    assign cmd.wr_lo    = wr_i && sel && (off_i == OFF_LO);
    assign cmd.wr_norst = wr_i && sel && (off_i == OFF_NORST);
    assign cmd.wr_run   = wr_i && sel && (off_i == OFF_RUN);
    assign cmd.rd_hi    = rd_i && sel && (off_i == OFF_HI);
    assign cmd.wdata    = wdata_i;

    dmt_cpu_timer u_tmr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick),
      .user_i       (mode_q[i]),
      .enter_user_i (to_user[i]),
      .enter_ctr_i  (to_ctr[i]),
      .cmd_i        (cmd),
      .rd_hi_o      (hi_w[i]),
      .rd_lo_o      (lo_w[i]),
      .run_o        (run_w[i]),
      .reached_o    (reach_w[i]),
      .irq_o        (irq_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (win_i == '0) begin
      if (off_i == OFF_MODE) rdata_o[N_CPU-1:0] = mode_q;
    end else begin
      for (int i = 0; i < N_CPU; i++) begin
        if (win_i == WW'(i + 1)) begin
          case (off_i)
            OFF_HI:  rdata_o = hi_w[i];
            OFF_LO:  rdata_o = lo_w[i];
            OFF_RUN: rdata_o = {31'b0, run_w[i]};
            default: rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dmt_chk.sv
module dmt_chk #(
  parameter int N_CPU = 2,
  parameter int WW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [WW-1:0]    win_i,
  input logic [4:0]       off_i,
  input logic [31:0]      wdata_i,
  input logic [N_CPU-1:0] mode_i,
  input logic [N_CPU-1:0] run_i,
  input logic [N_CPU-1:0] reach_i,
  input logic [N_CPU-1:0] irq_i
);
  AST_MODE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && win_i == '0 && off_i == 5'h10) |=> (mode_i == $past(wdata_i[N_CPU-1:0]))); // R2

  for (genvar i = 0; i < N_CPU; i++) begin : g_chk
    AST_USER_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i[i] |-> !irq_i[i]); // R10
    AST_ENTER_USER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mode_i[i]) |-> (!run_i[i] && !irq_i[i])); // R7
    AST_CTR_ALWAYS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode_i[i] |-> run_i[i]); // R6
    AST_IRQ_WITH_REACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_i[i]) |-> (reach_i[i] && !mode_i[i])); // R3
  end
endmodule

bind dual_mode_timer dmt_chk #(.N_CPU(N_CPU), .WW(WW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .win_i   (win_i),
  .off_i   (off_i),
  .wdata_i (wdata_i),
  .mode_i  (mode_q),
  .run_i   (run_w),
  .reach_i (reach_w),
  .irq_i   (irq_o)
);

// File: tb/dual_mode_timer_tb.sv
module dual_mode_timer_tb;
  localparam int DIV = 4;
  localparam int N   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  win = '0;
  logic [4:0]  off = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic [N-1:0] irq;
  int n_chk = 0, n_fail = 0;
  logic [31:0] r;

  always #5 clk = ~clk;

  dual_mode_timer #(.N_CPU(N), .TICK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .win_i(win),
    .off_i(off), .wdata_i(wd), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic        w;
    logic [1:0]  win;
    logic [4:0]  off;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // register-level vectors, deterministic because user counters are stopped
  localparam vec_t VEC [19] = '{
    '{1'b0, 2'd0, 5'h10, 32'h0,        32'h0,        8'd1},  // R1 mode 0
    '{1'b0, 2'd1, 5'h0C, 32'h0,        32'h1,        8'd1},  // R1 running
    '{1'b0, 2'd2, 5'h0C, 32'h0,        32'h1,        8'd1},
    '{1'b0, 2'd1, 5'h00, 32'h0,        32'h0,        8'd1},  // R1 limit 0
    '{1'b1, 2'd0, 5'h10, 32'hFFFFFFFF, 32'h0,        8'd2},
    '{1'b0, 2'd0, 5'h10, 32'h0,        32'h3,        8'd2},  // R2
    '{1'b0, 2'd1, 5'h0C, 32'h0,        32'h0,        8'd7},  // R7 stopped
    '{1'b0, 2'd2, 5'h0C, 32'h0,        32'h0,        8'd7},
    '{1'b0, 2'd1, 5'h00, 32'h0,        32'h0,        8'd7},  // R7 count cleared
    '{1'b0, 2'd1, 5'h04, 32'h0,        32'h0,        8'd7},
    '{1'b1, 2'd1, 5'h00, 32'h92345678, 32'h0,        8'd9},
    '{1'b1, 2'd1, 5'h04, 32'hABCDEF77, 32'h0,        8'd9},
    '{1'b0, 2'd1, 5'h00, 32'h0,        32'h12345678, 8'd9},  // R9
    '{1'b0, 2'd1, 5'h04, 32'h0,        32'hABCDEE00, 8'd9},
    '{1'b1, 2'd2, 5'h04, 32'h00000400, 32'h0,        8'd9},
    '{1'b0, 2'd2, 5'h04, 32'h0,        32'h00000400, 8'd9},
    '{1'b0, 2'd1, 5'h04, 32'h0,        32'hABCDEE00, 8'd9},
    '{1'b1, 2'd0, 5'h10, 32'h0,        32'h0,        8'd11},
    '{1'b0, 2'd1, 5'h0C, 32'h0,        32'h1,        8'd11}  // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // caller sits at a negedge; the access takes effect at the next posedge
  task automatic op(input logic w, input logic [1:0] wi, input logic [4:0] o,
                    input logic [31:0] d, output logic [31:0] res);
    wr = w; rd = !w; win = wi; off = o; wd = d;
    #1 res = rdata;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 irq", 32'(irq), 32'h0);

    foreach (VEC[i]) begin
      op(VEC[i].w, VEC[i].win, VEC[i].off, VEC[i].data, r);
      if (!VEC[i].w) check($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
    end
    op(1'b0, 2'd1, 5'h00, 0, r);
    check("R11 limit", r, 32'h0);

    // R3 / R4: limit of 3 periods
    op(1'b1, 2'd1, 5'h00, 32'h600, r);
    idle(2*DIV);
    check("R3 no irq yet", 32'(irq[0]), 0);
    idle(DIV);
    check("R3 irq at limit", 32'(irq[0]), 1);
    op(1'b0, 2'd1, 5'h04, 0, r);
    check("R3 reached and wrap", r, 32'h80000000);
    op(1'b0, 2'd1, 5'h00, 0, r);
    check("R4 limit read", r, 32'h600);
    check("R4 irq cleared", 32'(irq[0]), 0);
    op(1'b0, 2'd1, 5'h04, 0, r);
    check("R4 reached cleared", 32'(r[31]), 0);

    // R5 / R12: free run, then non-clearing limit write
    op(1'b1, 2'd1, 5'h00, 32'h0, r);
    idle(5*DIV);
    op(1'b0, 2'd1, 5'h04, 0, r);
    check("R12 five ticks", r, 32'h00000A00);
    op(1'b1, 2'd1, 5'h08, 32'h00000E00, r);
    idle(3*DIV);
    check("R5 irq without count reset", 32'(irq[0]), 1);
    op(1'b0, 2'd1, 5'h00, 0, r);
    check("R5 limit", r, 32'h00000E00);

    // R6: ignored writes in counter mode
    op(1'b1, 2'd1, 5'h00, 32'h00000E00, r);
    idle(4*DIV);
    op(1'b1, 2'd1, 5'h04, 32'h0, r);
    op(1'b1, 2'd1, 5'h0C, 32'h0, r);
    op(1'b0, 2'd1, 5'h0C, 0, r);
    check("R6 still running", r, 32'h1);
    op(1'b0, 2'd1, 5'h04, 0, r);
    check("R6 count kept", 32'(r[30:9] >= 22'd4), 1);

    // R7: switch with interrupt pending
    idle(4*DIV);
    check("R3 irq pending", 32'(irq[0]), 1);
    op(1'b1, 2'd0, 5'h10, 32'h1, r);
    check("R7 irq lowered", 32'(irq[0]), 0);
    op(1'b0, 2'd1, 5'h0C, 0, r);
    check("R7 stopped", r, 32'h0);
    op(1'b0, 2'd1, 5'h04, 0, r);
    check("R7 count zero", r, 32'h0);
    op(1'b0, 2'd1, 5'h00, 0, r);
    check("R9 reached in high word", r, 32'h80000000);
    op(1'b0, 2'd2, 5'h0C, 0, r);
    check("R2 other cpu untouched", r, 32'h1);

    // R8 / R12: start, count exactly 6 periods, stop
    op(1'b1, 2'd1, 5'h04, 32'h0, r);
    op(1'b1, 2'd1, 5'h00, 32'h0, r);
    op(1'b1, 2'd1, 5'h0C, 32'h1, r);
    op(1'b0, 2'd1, 5'h0C, 0, r);
    check("R8 started", r, 32'h1);
    idle(6*DIV - 2);
    op(1'b1, 2'd1, 5'h0C, 32'h0, r);
    op(1'b0, 2'd1, 5'h0C, 0, r);
    check("R8 stopped", r, 32'h0);
    op(1'b0, 2'd1, 5'h04, 0, r);
    check("R12 six ticks", r, 32'h00000C00);
    idle(3*DIV);
    op(1'b0, 2'd1, 5'h04, 0, r);
    check("R8 holds when stopped", r, 32'h00000C00);

    // R10: wrap at the 64-bit limit on cpu 2
    op(1'b1, 2'd0, 5'h10, 32'h3, r);
    op(1'b0, 2'd2, 5'h00, 0, r);
    check("R10 fresh high word", r, 32'h0);
    op(1'b1, 2'd2, 5'h00, 32'h7FFFFFFF, r);
    op(1'b1, 2'd2, 5'h04, 32'hFFFFFC00, r);
    op(1'b0, 2'd2, 5'h04, 0, r);
    check("R9 low word load", r, 32'hFFFFFC00);
    op(1'b1, 2'd2, 5'h0C, 32'h1, r);
    idle(2*DIV - 1);
    op(1'b1, 2'd2, 5'h0C, 32'h0, r);
    op(1'b0, 2'd2, 5'h00, 0, r);
    check("R10 wrapped with reached", r, 32'h80000000);
    op(1'b0, 2'd2, 5'h04, 0, r);
    check("R10 one tick past wrap", r, 32'h00000200);
    check("R10 no irq", 32'(irq), 32'h0);

    // R11: back to counter mode, limit of 7 kept, count restarted
    op(1'b1, 2'd0, 5'h10, 32'h0, r);
    op(1'b0, 2'd1, 5'h0C, 0, r);
    check("R11 running again", r, 32'h1);
    op(1'b0, 2'd1, 5'h00, 0, r);
    check("R11 limit kept", r, 32'h00000E00);
    idle(5*DIV - 2);
    check("R11 no irq before limit", 32'(irq[0]), 0);
    idle(2*DIV);
    check("R11 irq after 7 periods", 32'(irq[0]), 1);
    op(1'b0, 2'd2, 5'h0C, 0, r);
    check("R11 cpu2 running", r, 32'h1);

    finish_run();
  end
endmodule